// File: doc/BRIEF.md
# Per-Channel Frame Pairing Monitor

This block watches decoded packet headers from a camera-style serial receiver. It keeps a separate frame record for each of four virtual channels. Each channel has an open-frame flag, set by a frame-start short packet and cleared by a frame-end short packet, and a sticky flag that records payload CRC failures reported at the end of long packets. When the markers arrive out of order, for example a second start, a stray end or a repeated end, the block pulses a frame sync error for that channel. When an end closes a frame that carried a bad payload, it pulses a frame data error for that channel. These pulses feed the set inputs of a status register.

Two header failures make the channel ID unreliable: a start-of-transmission sync failure and an uncorrectable double-bit header error. Either one drops the packet and is charged as a frame sync error to the channel that last carried an accepted packet. The `process_o` flag tells the downstream packet handler whether the current header may be used.

Top module: `vc_frame_checker`

## Requirements
- R1: After reset, both error outputs are zero and no channel has an open frame. The most recently active channel is channel 0.
- R2: A frame start (data type 0x00) on a channel whose frame is already open produces a one-cycle `fsync_err_o` pulse on that channel's bit in the next cycle. The frame stays open and `process_o` stays high.
- R3: A frame end (data type 0x01) on a channel with no open frame produces a `fsync_err_o` pulse on that channel in the next cycle, with `process_o` high. This includes a second end following an end.
- R4: A frame end on an open frame produces an `fdata_err_o` pulse on that channel in the next cycle if any long-packet end with the CRC flag set arrived on that channel since the frame start. Otherwise no pulse is produced.
- R5: The four channels, selected by the 2-bit `vc_i`, are tracked independently. Channel n maps to bit n of each error output.
- R6: While `sot_sync_err_i` or `ecc_dbl_err_i` is high, `process_o` is low and every packet input of that cycle is ignored. In the next cycle a `fsync_err_o` pulse appears on the most recently active channel, meaning the channel of the last accepted short packet or long-packet end.
- R7: A frame start clears the channel's CRC history. A CRC error reported in the same cycle as the frame start on that channel is discarded.
- R8: A CRC error reported in the same cycle as the frame end on the same channel counts toward that frame's data error.
- R9: Every error pulse lasts exactly one cycle unless a new triggering event occurs.
- R10: Short packets with any other data type (for example 0x02 or 0x03) do not change the frame state of any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_valid_i | input | 1 | Short packet header valid this cycle |
| sp_dt_i | input | 6 | Short packet data type |
| vc_i | input | 2 | Virtual channel of the current packet event |
| lp_end_i | input | 1 | End of a long packet this cycle |
| lp_crc_err_i | input | 1 | The ending long packet failed its CRC |
| sot_sync_err_i | input | 1 | Start-of-transmission sync failure on the current packet |
| ecc_dbl_err_i | input | 1 | Uncorrectable double-bit header error on the current packet |
| fsync_err_o | output | 4 | Per-channel frame sync error pulse |
| fdata_err_o | output | 4 | Per-channel frame data error pulse |
| process_o | output | 1 | Current packet may be processed |

## Verification
A long-packet end carrying a CRC error can arrive in the same cycle as a frame marker for the same channel. With a frame end it must count toward the closing frame. With a frame start it must be thrown away. The bench drives both coincidences from its vector table and judges them by whether `fdata_err_o` pulses on the following frame end. A drop condition is also driven in the same cycle as a valid frame start. The start must be ignored, which the bench shows by the sync error that the next end raises on that channel.

// File: rtl/vc_frame_checker.sv
module vc_frame_checker #(
  parameter int NUM_VC = 4,
  parameter int VC_W   = 2,
  parameter int DT_W   = 6,
  parameter logic [DT_W-1:0] DT_FS = 0,
  parameter logic [DT_W-1:0] DT_FE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp_valid_i,
  input  logic [DT_W-1:0]   sp_dt_i,
  input  logic [VC_W-1:0]   vc_i,
  input  logic              lp_end_i,
  input  logic              lp_crc_err_i,
  input  logic              sot_sync_err_i,
  input  logic              ecc_dbl_err_i,
  output logic [NUM_VC-1:0] fsync_err_o,
  output logic [NUM_VC-1:0] fdata_err_o,
  output logic              process_o
);

  logic              drop;
  logic              accept;
  logic [VC_W-1:0]   last_q;
  logic [NUM_VC-1:0] open_q, crc_q, fs_hit, fe_hit, crc_hit, sync_d, data_d;

  assign drop      = sot_sync_err_i | ecc_dbl_err_i;
  assign accept    = ~drop;
  assign process_o = accept;

  generate
    for (genvar i = 0; i < NUM_VC; i++) begin : g_vc
      logic sel;
      assign sel       = (vc_i == VC_W'(i));
      assign fs_hit[i] = accept & sp_valid_i & sel & (sp_dt_i == DT_FS);
      assign fe_hit[i] = accept & sp_valid_i & sel & (sp_dt_i == DT_FE);
      assign crc_hit[i] = accept & lp_end_i & lp_crc_err_i & sel;

      assign sync_d[i] = (fs_hit[i] & open_q[i])
                       | (fe_hit[i] & ~open_q[i])
                       | (drop & (last_q == VC_W'(i)));
      assign data_d[i] = fe_hit[i] & open_q[i] & (crc_q[i] | crc_hit[i]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          open_q[i] <= 1'b0;
          crc_q[i]  <= 1'b0;
        end else if (fs_hit[i]) begin
          open_q[i] <= 1'b1;
          crc_q[i]  <= 1'b0;
        end else if (fe_hit[i]) begin
          open_q[i] <= 1'b0;
          crc_q[i]  <= 1'b0;
        end else if (crc_hit[i]) begin
          crc_q[i]  <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q      <= '0;
      fsync_err_o <= '0;
      fdata_err_o <= '0;
    end else begin
      if (accept && (sp_valid_i || lp_end_i)) last_q <= vc_i;
      fsync_err_o <= sync_d;
      fdata_err_o <= data_d;
    end
  end

endmodule

module vc_frame_checker_sva #(
  parameter int NUM_VC = 4,
  parameter int VC_W   = 2,
  parameter int DT_W   = 6,
  parameter logic [DT_W-1:0] DT_FE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sp_valid_i,
  input logic [DT_W-1:0]   sp_dt_i,
  input logic [VC_W-1:0]   vc_i,
  input logic              lp_end_i,
  input logic              lp_crc_err_i,
  input logic              sot_sync_err_i,
  input logic              ecc_dbl_err_i,
  input logic [NUM_VC-1:0] fsync_err_o,
  input logic [NUM_VC-1:0] fdata_err_o,
  input logic              process_o
);

  // R4: a data error only follows an accepted frame end
  a_r4_data_after_fe: assert property (@(posedge clk) disable iff (!rst_n)
    (fdata_err_o != '0) |-> $past(sp_valid_i && sp_dt_i == DT_FE && !sot_sync_err_i && !ecc_dbl_err_i));

  // R5: one header touches at most one channel
  a_r5_data_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fdata_err_o));

  // R6: a dropped packet charges exactly one channel
  a_r6_drop_charges_one: assert property (@(posedge clk) disable iff (!rst_n)
    (sot_sync_err_i || ecc_dbl_err_i) |=> ($countones(fsync_err_o) == 1));

  // R6: a dropped packet is never flagged for processing
  a_r6_drop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ecc_dbl_err_i) |-> !process_o);

  // R2, R3: sync errors need a header or a drop in the previous cycle
  a_r3_sync_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_err_o != '0) |-> $past(sp_valid_i || sot_sync_err_i || ecc_dbl_err_i));

  // R9: a data error never repeats on the same channel in the next cycle
  a_r9_data_single: assert property (@(posedge clk) disable iff (!rst_n)
    (fdata_err_o != '0) |=> ((fdata_err_o & $past(fdata_err_o)) == '0));

  // R9: no packet activity means no pulses next cycle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_valid_i && !lp_end_i && !sot_sync_err_i && !ecc_dbl_err_i) |=>
      (fsync_err_o == '0 && fdata_err_o == '0));

  logic unused_ok;
  assign unused_ok = &{1'b0, vc_i, lp_crc_err_i};

endmodule

bind vc_frame_checker vc_frame_checker_sva #(
  .NUM_VC(NUM_VC), .VC_W(VC_W), .DT_W(DT_W), .DT_FE(DT_FE)
) u_sva (.*);

// File: tb/vc_frame_checker_bench.sv
module vc_frame_checker_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sp_valid_i = 1'b0;
  logic [5:0] sp_dt_i = '0;
  logic [1:0] vc_i = '0;
  logic       lp_end_i = 1'b0;
  logic       lp_crc_err_i = 1'b0;
  logic       sot_sync_err_i = 1'b0;
  logic       ecc_dbl_err_i = 1'b0;
  logic [3:0] fsync_err_o, fdata_err_o;
  logic       process_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  vc_frame_checker u_vc_frame_checker (.*);

  // {sp, dt, vc, lp_end, crc, sot, ecc, exp_sync, exp_data, exp_proc}
  localparam int NV = 24;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,6'h00,2'd0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // FS vc0
    {1'b0,6'h00,2'd0,1'b1,1'b1,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // bad LP vc0
    {1'b1,6'h01,2'd0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0001,1'b1}, // R4 FE -> data err
    {1'b1,6'h01,2'd0,1'b0,1'b0,1'b0,1'b0,4'b0001,4'b0000,1'b1}, // R3 FE after FE
    {1'b1,6'h00,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // FS vc1
    {1'b1,6'h00,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0010,4'b0000,1'b1}, // R2 FS after FS
    {1'b0,6'h00,2'd2,1'b1,1'b1,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // bad LP vc2, R5
    {1'b1,6'h01,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // R5 vc1 clean end
    {1'b1,6'h00,2'd2,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // R7 FS clears vc2
    {1'b1,6'h01,2'd2,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // R7 no data err
    {1'b1,6'h00,2'd3,1'b0,1'b0,1'b1,1'b0,4'b0100,4'b0000,1'b0}, // R6 sot drop -> vc2
    {1'b1,6'h01,2'd3,1'b0,1'b0,1'b0,1'b0,4'b1000,4'b0000,1'b1}, // R6 FS was ignored
    {1'b1,6'h00,2'd3,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // FS vc3
    {1'b1,6'h01,2'd3,1'b1,1'b1,1'b0,1'b0,4'b0000,4'b1000,1'b1}, // R8 FE + bad LP
    {1'b0,6'h00,2'd0,1'b0,1'b0,1'b0,1'b1,4'b1000,4'b0000,1'b0}, // R6 ecc drop -> vc3
    {1'b1,6'h00,2'd0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // FS vc0
    {1'b1,6'h02,2'd0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // R10 other type
    {1'b1,6'h00,2'd0,1'b1,1'b1,1'b0,1'b0,4'b0001,4'b0000,1'b1}, // R7 FS + bad LP
    {1'b1,6'h01,2'd0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // R7 CRC discarded
    {1'b1,6'h00,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // FS vc1
    {1'b1,6'h03,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // R10 other type
    {1'b1,6'h01,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}, // R10 frame still open
    {1'b1,6'h01,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0010,4'b0000,1'b1}, // R3 stray FE
    {1'b0,6'h00,2'd0,1'b0,1'b0,1'b0,1'b0,4'b0000,4'b0000,1'b1}  // R9 pulse ends
  };

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(logic sp, logic [5:0] dt, logic [1:0] vc,
                       logic lp, logic crc, logic sot, logic ecc);
    sp_valid_i = sp; sp_dt_i = dt; vc_i = vc;
    lp_end_i = lp; lp_crc_err_i = crc;
    sot_sync_err_i = sot; ecc_dbl_err_i = ecc;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sync at reset", fsync_err_o, 4'b0000);
    check("R1 data at reset", fdata_err_o, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [21:0] v;
      v = VEC[k];
      drive(v[21], v[20:15], v[14:13], v[12], v[11], v[10], v[9]);
      #1;
      check($sformatf("R6 process row %0d", k), {3'b0, process_o}, {3'b0, v[0]});
      @(negedge clk);
      check($sformatf("R2/R3/R6 sync row %0d", k), fsync_err_o, v[8:5]);
      check($sformatf("R4/R8 data row %0d", k), fdata_err_o, v[4:1]);
    end

    // R1: reset mid-frame closes frames and returns the last channel to 0
    drive(1, 6'h00, 2'd2, 0, 0, 0, 0);
    @(negedge clk);
    drive(0, 6'h00, 2'd0, 0, 0, 0, 0);
    rst_n = 1'b0;
    #1;
    check("R1 sync in reset", fsync_err_o, 4'b0000);
    check("R1 data in reset", fdata_err_o, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(0, 6'h00, 2'd3, 0, 0, 0, 1);
    @(negedge clk);
    check("R1 drop after reset charges vc0", fsync_err_o, 4'b0001);
    drive(1, 6'h01, 2'd2, 0, 0, 0, 0);
    @(negedge clk);
    check("R1 frame closed by reset", fsync_err_o, 4'b0100);
    drive(0, 6'h00, 2'd0, 0, 0, 0, 0);
    @(negedge clk);
    check("R9 pulse cleared", fsync_err_o, 4'b0000);

    finish_run();
  end

endmodule